// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational arithmetic and logic unit assembled from a chain of identical one-bit slices. Each slice holds an input inverter for each operand, an AND gate, an OR gate and a full adder. A two-bit selector picks which of these the slice drives out, or a fourth input called `less`. The carry ripples from slice to slice. One negate strobe inverts the second operand in every slice and also drives the carry into bit 0, so the same adder serves for both sum and difference.

A four-bit control word sets the operation. With it a datapath can do bitwise AND, OR and NOR, two's-complement addition and subtraction, and a signed set-if-less-than. NOR comes out of the AND gate with both operands inverted, so no separate gate is needed. Set-if-less-than runs a subtraction and feeds the MSB slice's adder bit back into the `less` input of bit 0. Every other `less` input is tied low. A branch-on-equal or branch-on-not-equal decision uses the subtract code and reads the zero flag. Overflow is formed only at the MSB slice.

Top module: `alu_sliced`

## Requirements
- R1: Control word 4'b0000 drives `result` with the bitwise AND of `opA` and `opB`.
- R2: Control word 4'b0001 drives `result` with the bitwise OR of `opA` and `opB`.
- R3: Control word 4'b0010 drives `result` with `opA + opB` modulo 2^WIDTH, and `carryOut` with the carry out of the top bit.
- R4: Control word 4'b0110 drives `result` with `opA - opB` modulo 2^WIDTH, and `carryOut` with 1 exactly when `opA >= opB` taken as unsigned numbers.
- R5: Control word 4'b1100 drives `result` with the bitwise NOR of `opA` and `opB`.
- R6: Control word 4'b0111 drives `result` with zeros in bits WIDTH-1..1, and in bit 0 the top bit of `opA - opB` modulo 2^WIDTH. This is the raw sign, with no correction when the difference overflows.
- R7: `zero` is 1 exactly when every bit of `result` is 0, under every control word.
- R8: `overflow` equals the carry into the top bit XOR the carry out of it. For addition this means both operands share a sign and the sum's sign differs. For subtraction it means the operands' signs differ and the difference's sign differs from `opA`.
- R9: The control word fields are bit 3 = invert A, bit 2 = negate B (B inverted and carry-in 1), and bits 1:0 = select: 00 AND, 01 OR, 10 adder sum, 11 less input. Any combination follows these rules. For example, 4'b1101 gives NAND and 4'b1000 gives `~opA & opB`.
- R10: Under the subtract code, `zero` is 1 when `opA == opB` and 0 when they differ, which is enough for both branch-on-equal and branch-on-not-equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| ctrlWord | input | 4 | {invert A, negate B, select[1:0]} |
| result | output | WIDTH | Selected slice outputs |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the adder chain |
| carryOut | output | 1 | Carry out of the MSB slice |

## Verification
The bench builds the block with the default WIDTH of 32. At that width a carry has to ripple through all 32 slices, and the MSB sum bit has to travel back across the whole chain to reach bit 0 for set-if-less-than. Operands such as 32'h7FFFFFFF, 32'h80000000 and 32'hFFFFFFFF then exercise signed overflow, the full-length carry, and the uncorrected sign seen by set-if-less-than. A sweep of all sixteen control words with pseudo-random operands checks that the invert and negate strobes combine freely with every selector value.

// File: rtl/alu_sliced_pkg.sv
package alu_sliced_pkg;
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sliceSel_e;

  typedef struct packed {
    logic      invA;
    logic      negB;
    sliceSel_e sel;
  } aluStrobes_t;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_sliced_pkg::*;
(
  input  logic      a,
  input  logic      b,
  input  logic      invA,
  input  logic      negB,
  input  logic      carryIn,
  input  logic      less,
  input  sliceSel_e sel,
  output logic      result,
  output logic      carryOut,
  output logic      sumBit
);
  logic aEff;
  logic bEff;

  // Operand conditioning: per-slice inverters
  assign aEff = invA ? ~a : a;
  assign bEff = negB ? ~b : b;

  // Full adder
  assign sumBit   = aEff ^ bEff ^ carryIn;
  assign carryOut = (aEff & bEff) | (aEff & carryIn) | (bEff & carryIn);

  always_comb begin
    unique case (sel)
      SEL_AND:  result = aEff & bEff;
      SEL_OR:   result = aEff | bEff;
      SEL_SUM:  result = sumBit;
      SEL_LESS: result = less;
      default:  result = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_control.sv
module alu_control
  import alu_sliced_pkg::*;
(
  input  logic [3:0]  ctrlWord,
  output aluStrobes_t strobes
);
  // Field placement: [3] invert A, [2] negate B, [1:0] selector
  assign strobes.invA = ctrlWord[3];
  assign strobes.negB = ctrlWord[2];
  assign strobes.sel  = sliceSel_e'(ctrlWord[1:0]);
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_sliced_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH-1:0] lessIn;

  // The negate strobe doubles as the +1 of the two's complement
  assign carryChain[0] = strobes.negB;

  // Only bit 0 sees the MSB adder bit; all others read zero
  assign lessIn = {{(WIDTH-1){1'b0}}, sumBits[MSB]};

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a        (opA[i]),
      .b        (opB[i]),
      .invA     (strobes.invA),
      .negB     (strobes.negB),
      .carryIn  (carryChain[i]),
      .less     (lessIn[i]),
      .sel      (strobes.sel),
      .result   (result[i]),
      .carryOut (carryChain[i+1]),
      .sumBit   (sumBits[i])
    );
  end

  assign zero     = ~|result;
  // Overflow formed at the MSB slice only
  assign overflow = carryChain[MSB] ^ carryChain[WIDTH];
  assign carryOut = carryChain[WIDTH];
endmodule

// File: rtl/alu_sliced.sv
module alu_sliced
  import alu_sliced_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       ctrlWord,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);
  aluStrobes_t strobes;

  alu_control u_control (
    .ctrlWord (ctrlWord),
    .strobes  (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .zero     (zero),
    .overflow (overflow),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/alu_sliced_checker.sv
module alu_sliced_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       ctrlWord,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow,
  input logic             carryOut
);
  localparam int MSB = WIDTH - 1;

  logic unusedCarry;
  assign unusedCarry = carryOut;

  always_comb begin
    if (ctrlWord == 4'b0000)
      p_and_r1: assert (result == (opA & opB));
    if (ctrlWord == 4'b0001)
      p_or_r2: assert (result == (opA | opB));
    if (ctrlWord == 4'b0010)
      p_add_r3: assert (result == opA + opB);
    if (ctrlWord == 4'b0110)
      p_sub_r4: assert (result == opA - opB);
    if (ctrlWord == 4'b1100)
      p_nor_r5: assert (result == ~(opA | opB));
    if (ctrlWord == 4'b0111)
      p_slt_upper_r6: assert (result[MSB:1] == '0);
    if (ctrlWord == 4'b0010)
      p_add_overflow_r8: assert (overflow ==
        ((opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB])));
    if (ctrlWord == 4'b0110 && opA == opB)
      p_beq_zero_r10: assert (zero);
  end
endmodule

bind alu_sliced alu_sliced_checker #(.WIDTH(WIDTH)) u_checker (
  .opA      (opA),
  .opB      (opB),
  .ctrlWord (ctrlWord),
  .result   (result),
  .zero     (zero),
  .overflow (overflow),
  .carryOut (carryOut)
);

// File: tb/alu_sliced_test.sv
module alu_sliced_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 32;
  localparam int NUM_VEC    = 12;
  localparam int WATCHDOG   = 20000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic [3:0]       ctrlWord = '0;
  logic [WIDTH-1:0] result;
  logic             zero;
  logic             overflow;
  logic             carryOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_sliced #(.WIDTH(WIDTH)) uut (
    .opA(opA), .opB(opB), .ctrlWord(ctrlWord),
    .result(result), .zero(zero), .overflow(overflow), .carryOut(carryOut)
  );

  // {ctrlWord, opA, opB, expected result}
  localparam logic [99:0] VEC [NUM_VEC] = '{
    {4'h0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000}, // R1
    {4'h1, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0}, // R2
    {4'h2, 32'h00000005, 32'h00000003, 32'h00000008}, // R3
    {4'h6, 32'h00000005, 32'h00000003, 32'h00000002}, // R4
    {4'hC, 32'h0000FFFF, 32'h00FF0000, 32'hFF000000}, // R5
    {4'h7, 32'h00000003, 32'h00000005, 32'h00000001}, // R6
    {4'h7, 32'h00000005, 32'h00000003, 32'h00000000}, // R6
    {4'h7, 32'hFFFFFFFF, 32'h00000001, 32'h00000001}, // R6
    {4'h6, 32'h12345678, 32'h12345678, 32'h00000000}, // R10
    {4'hD, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FFF0FFF}, // R9
    {4'h8, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0F000F00}, // R9
    {4'h2, 32'hFFFFFFFF, 32'h00000001, 32'h00000000}  // R3
  };

  // Behavioural model: {carryOut, overflow, zero, result}
  function automatic logic [WIDTH+2:0] model(input logic [3:0] c,
                                             input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] ea;
    logic [WIDTH-1:0] eb;
    logic [WIDTH:0]   full;
    logic [WIDTH-1:0] low;
    logic [WIDTH-1:0] r;
    ea   = c[3] ? ~a : a;
    eb   = c[2] ? ~b : b;
    full = {1'b0, ea} + {1'b0, eb} + (WIDTH+1)'(c[2]);
    low  = {1'b0, ea[WIDTH-2:0]} + {1'b0, eb[WIDTH-2:0]} + WIDTH'(c[2]);
    case (c[1:0])
      2'b00:   r = ea & eb;
      2'b01:   r = ea | eb;
      2'b10:   r = full[WIDTH-1:0];
      default: r = {{(WIDTH-1){1'b0}}, full[WIDTH-1]};
    endcase
    return {full[WIDTH], low[WIDTH-1] ^ full[WIDTH], (r == '0), r};
  endfunction

  task automatic check(input string tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [WIDTH-1:0] a,
                       input logic [WIDTH-1:0] b);
    @(negedge clk);
    ctrlWord = c;
    opA = a;
    opB = b;
    #(CLK_PERIOD/4);
  endtask

  task automatic checkModel(input string tag);
    logic [WIDTH+2:0] m;
    m = model(ctrlWord, opA, opB);
    check({tag, " result"}, result, m[WIDTH-1:0]);
    check("R7 zero", WIDTH'(zero), WIDTH'(m[WIDTH]));
    check("R8 overflow", WIDTH'(overflow), WIDTH'(m[WIDTH+1]));
    check({tag, " carryOut"}, WIDTH'(carryOut), WIDTH'(m[WIDTH+2]));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [WIDTH-1:0] lfsrA;
    logic [WIDTH-1:0] lfsrB;
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // Quiet state: all-zero inputs give zero result and zero flag set
    apply(4'h0, '0, '0);
    check("R1 idle result", result, '0);
    check("R7 idle zero", WIDTH'(zero), WIDTH'(1));

    // Table walk
    for (int i = 0; i < NUM_VEC; i++) begin
      apply(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32]);
      check($sformatf("table %0d expected", i), result, VEC[i][31:0]);
      checkModel($sformatf("table %0d model", i));
    end

    // R3 full-length carry
    apply(4'h2, 32'hFFFFFFFF, 32'h00000001);
    check("R3 carry out", WIDTH'(carryOut), WIDTH'(1));
    check("R7 zero on wrap", WIDTH'(zero), WIDTH'(1));

    // R4 borrow convention
    apply(4'h6, 32'h00000003, 32'h00000005);
    check("R4 no-carry when a<b", WIDTH'(carryOut), WIDTH'(0));
    check("R4 difference", result, 32'hFFFFFFFE);

    // R8 overflow cases
    apply(4'h2, 32'h7FFFFFFF, 32'h00000001);
    check("R8 add overflow", WIDTH'(overflow), WIDTH'(1));
    apply(4'h6, 32'h80000000, 32'h00000001);
    check("R8 sub overflow", WIDTH'(overflow), WIDTH'(1));
    apply(4'h2, 32'h00000005, 32'h00000003);
    check("R8 no overflow", WIDTH'(overflow), WIDTH'(0));

    // R6 raw sign without overflow correction
    apply(4'h7, 32'h7FFFFFFF, 32'hFFFFFFFF);
    check("R6 raw sign on overflow", result, 32'h00000001);
    check("R8 slt overflow flag", WIDTH'(overflow), WIDTH'(1));

    // R10 branch decision
    apply(4'h6, 32'hDEADBEEF, 32'hDEADBEEF);
    check("R10 equal zero", WIDTH'(zero), WIDTH'(1));
    apply(4'h6, 32'hDEADBEEF, 32'hDEADBEEE);
    check("R10 unequal zero", WIDTH'(zero), WIDTH'(0));

    // R9 sweep of every control word
    lfsrA = 32'h1D872B41;
    lfsrB = 32'h9E3779B9;
    for (int k = 0; k < 64; k++) begin
      for (int c = 0; c < 16; c++) begin
        apply(4'(c), lfsrA, lfsrB);
        checkModel("R9 sweep");
        lfsrA = {lfsrA[30:0], lfsrA[31] ^ lfsrA[21] ^ lfsrA[1] ^ lfsrA[0]};
        lfsrB = {lfsrB[30:0], lfsrB[31] ^ lfsrB[21] ^ lfsrB[1] ^ lfsrB[0]};
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule